// File: doc/BRIEF.md
# CAN Node Sleep and Wake-up Controller

This block decides when a CAN controller may power down and when it must come back. The host asks for sleep by writing a sleep bit. The request is honoured only when the node is quiet: no interrupt is pending, the bus is idle and the external interrupt line is high. A request made at any other time raises a wake-up interrupt and the node stays awake. Sleep requests are also refused while the controller is in reset mode. They stay refused after reset mode ends until the bus-free detector has reported an idle bus again.

Once asleep, the block keeps the oscillator and the clock output running for a fixed number of bit times. A host that is clocked from that output then has time to enter its own standby state before the clock stops. Three events end sleep: the host clears the sleep bit, the bus becomes active, or the external interrupt line goes low. Each of these restarts the oscillator and sends a one-cycle wake-up interrupt request to the interrupt register. If the wake was caused by bus traffic, the receive-enable output stays low until a bus-free sequence has been seen, so the frame that woke the node is not taken as a valid reception.

Top module: `can_sleep_ctl`

## Requirements
- R1: After reset, `asleep` is 0, `osc_en` and `clkout_en` are 1, `wake_irq` is 0 and `rx_en` is 1.
- R2: The node enters sleep on the clock edge that samples an accepted sleep write. A sleep write is `set_wr`=1 with `set_val`=1, while `reset_mode`=0, sleep is permitted, `irq_pending`=0, `bus_active`=0 and `int_n`=1. From the next cycle `asleep` is 1. A sleep write made while already asleep changes nothing.
- R3: A sleep write that would otherwise be accepted, but arrives while `irq_pending`=1, `bus_active`=1 or `int_n`=0, leaves `asleep` at 0 and makes `wake_irq` 1 in the following cycle.
- R4: While `reset_mode`=1, sleep writes are ignored. After `reset_mode` returns to 0, they stay ignored, with no sleep and no `wake_irq`, until a `bus_free` pulse has been sampled.
- R5: While asleep, `clkout_en` and `osc_en` stay 1 until HOLD_BITS pulses of `bit_tick` have been sampled. Both fall in the cycle after the edge that samples the HOLD_BITS-th pulse. While awake, both are 1.
- R6: While asleep, any one of `set_wr`=1 with `set_val`=0, `bus_active`=1 or `int_n`=0 makes `asleep` 0 from the next cycle, with `osc_en` and `clkout_en` back at 1.
- R7: `wake_irq` is a pulse exactly one cycle long. It is issued together with the exit from sleep, or after a refused sleep write.
- R8: `rx_en` is 0 while asleep. After a wake caused by `bus_active`, it stays 0 until a `bus_free` pulse is sampled. After any other wake, it is 1 at once.
- R9: The clock-output hold count restarts from zero on every new entry into sleep. If sleep is left partway through the hold, the next sleep again keeps the clock for the full HOLD_BITS ticks.
- R10: `reset_mode`=1 forces the node awake from the next cycle, without a `wake_irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_wr | input | 1 | One-cycle strobe: host writes the sleep bit |
| set_val | input | 1 | Value written with `set_wr` (1 = sleep, 0 = wake) |
| reset_mode | input | 1 | Controller is in reset mode |
| irq_pending | input | 1 | Some controller interrupt is pending |
| bus_active | input | 1 | Bus activity detected |
| int_n | input | 1 | Level of the external interrupt line, active low |
| bus_free | input | 1 | One-cycle pulse: 11 recessive bits seen |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| asleep | output | 1 | Node is in sleep mode |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock-output enable |
| wake_irq | output | 1 | One-cycle wake-up interrupt request |
| rx_en | output | 1 | Reception permitted for the protocol engine |

## Verification
The assertions assume the input strobes behave as their producers guarantee. `set_wr`, `bus_free` and `bit_tick` are treated as single-cycle pulses. `bus_free` is never raised in the same cycle as `bus_active`, because a bus cannot be both idle and busy. The stimulus table respects this: every strobe is held for exactly one row, and idle-bus and busy-bus rows never overlap. The bench overrides HOLD_BITS to a small value so that the whole hold window, and an early exit from it, fit in a few rows.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;
   typedef enum logic {
      ST_AWAKE  = 1'b0,
      ST_ASLEEP = 1'b1
   } csc_state_e;

   function automatic int csc_cnt_width(input int hold_bits);
      return (hold_bits < 1) ? 1 : $clog2(hold_bits + 1);
   endfunction
endpackage

// File: rtl/csc_entry_gate.sv
// Tracks whether a sleep request may be honoured: cleared in reset mode,
// re-armed only by a bus-free indication seen outside reset mode.
module csc_entry_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic reset_mode,
   input  logic bus_free,
   output logic permit
);
   logic permit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          permit_q <= 1'b0;
      else if (reset_mode) permit_q <= 1'b0;
      else if (bus_free)   permit_q <= 1'b1;
   end

   assign permit = permit_q;
endmodule

// File: rtl/csc_mode_fsm.sv
// Two-state sleep machine with wake-up interrupt pulse generation.
module csc_mode_fsm
   import can_sleep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_wr,
   input  logic set_val,
   input  logic reset_mode,
   input  logic permit,
   input  logic irq_pending,
   input  logic bus_active,
   input  logic int_n,
   output logic asleep,
   output logic wake_irq,
   output logic bus_wake
);
   csc_state_e state_q, state_d;
   logic       irq_q;
   logic       quiet, try_sleep, go_sleep, refuse, wake_any;

   assign quiet     = !irq_pending && !bus_active && int_n;
   assign try_sleep = set_wr && set_val && !reset_mode && permit &&
                      (state_q == ST_AWAKE);
   assign go_sleep  = try_sleep && quiet;
   assign refuse    = try_sleep && !quiet;
   assign wake_any  = (state_q == ST_ASLEEP) && !reset_mode &&
                      ((set_wr && !set_val) || bus_active || !int_n);
   assign bus_wake  = wake_any && bus_active;

   always_comb begin
      state_d = state_q;
      if (reset_mode)    state_d = ST_AWAKE;
      else if (go_sleep) state_d = ST_ASLEEP;
      else if (wake_any) state_d = ST_AWAKE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= refuse || wake_any;
      end
   end

   assign asleep   = (state_q == ST_ASLEEP);
   assign wake_irq = irq_q;
endmodule

// File: rtl/csc_hold_timer.sv
// Counts bit ticks after sleep entry; reports when the clock output may stop.
module csc_hold_timer
   import can_sleep_pkg::*;
#(
   parameter int HOLD_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic asleep,
   input  logic bit_tick,
   output logic hold_done
);
   localparam int CNT_W = csc_cnt_width(HOLD_BITS);

   generate
      if (HOLD_BITS == 0) begin : g_no_hold
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ asleep ^ bit_tick;
         assign hold_done = 1'b1;
      end else begin : g_counted
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_BITS);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (!asleep)                 cnt_q <= '0;
            else if (bit_tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end

         assign hold_done = (cnt_q == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/csc_rx_gate.sv
// Blocks reception after a bus-activity wake until bus-free is observed.
module csc_rx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic reset_mode,
   input  logic bus_wake,
   input  logic bus_free,
   input  logic asleep,
   output logic rx_en
);
   logic block_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          block_q <= 1'b0;
      else if (reset_mode) block_q <= 1'b0;
      else if (bus_wake)   block_q <= 1'b1;
      else if (bus_free)   block_q <= 1'b0;
   end

   assign rx_en = !asleep && !block_q;
endmodule

// File: rtl/can_sleep_ctl.sv
module can_sleep_ctl #(
   parameter int HOLD_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wr,
   input  logic set_val,
   input  logic reset_mode,
   input  logic irq_pending,
   input  logic bus_active,
   input  logic int_n,
   input  logic bus_free,
   input  logic bit_tick,
   output logic asleep,
   output logic osc_en,
   output logic clkout_en,
   output logic wake_irq,
   output logic rx_en
);
   generate
      if (HOLD_BITS < 0 || HOLD_BITS > 65535) begin : g_bad_hold
         $error("can_sleep_ctl: HOLD_BITS must lie in 0..65535");
      end
   endgenerate

   logic sleep_ok;
   logic bus_wake;
   logic hold_done;
   logic clk_run;

   csc_entry_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_mode (reset_mode),
      .bus_free   (bus_free),
      .permit     (sleep_ok)
   );

   csc_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_wr      (set_wr),
      .set_val     (set_val),
      .reset_mode  (reset_mode),
      .permit      (sleep_ok),
      .irq_pending (irq_pending),
      .bus_active  (bus_active),
      .int_n       (int_n),
      .asleep      (asleep),
      .wake_irq    (wake_irq),
      .bus_wake    (bus_wake)
   );

   csc_hold_timer #(.HOLD_BITS(HOLD_BITS)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .asleep    (asleep),
      .bit_tick  (bit_tick),
      .hold_done (hold_done)
   );

   csc_rx_gate u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_mode (reset_mode),
      .bus_wake   (bus_wake),
      .bus_free   (bus_free),
      .asleep     (asleep),
      .rx_en      (rx_en)
   );

   assign clk_run   = !(asleep && hold_done);
   assign osc_en    = clk_run;
   assign clkout_en = clk_run;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
   parameter int HOLD_BITS = 15
) (
   input logic clk,
   input logic rst_n,
   input logic set_wr,
   input logic set_val,
   input logic reset_mode,
   input logic irq_pending,
   input logic bus_active,
   input logic int_n,
   input logic sleep_ok,
   input logic asleep,
   input logic osc_en,
   input logic clkout_en,
   input logic wake_irq,
   input logic rx_en
);
   a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr && set_val && sleep_ok && !reset_mode && !irq_pending &&
       !bus_active && int_n && !asleep) |=> asleep);

   a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr && set_val && sleep_ok && !reset_mode && !asleep &&
       (irq_pending || bus_active || !int_n)) |=> (!asleep && wake_irq));

   a_r4_no_permit_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode |=> !sleep_ok);

   a_r5_clock_while_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !asleep |-> (clkout_en && osc_en));

   a_r5_clock_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> (clkout_en || HOLD_BITS == 0));

   a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !reset_mode && (bus_active || !int_n)) |=> !asleep);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);

   a_r8_no_rx_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !rx_en);

   a_r8_bus_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && bus_active && !reset_mode) |=> !rx_en);

   a_r10_reset_wakes_quietly: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode |=> (!asleep && !wake_irq));
endmodule

bind can_sleep_ctl csc_checker #(.HOLD_BITS(HOLD_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .set_wr      (set_wr),
   .set_val     (set_val),
   .reset_mode  (reset_mode),
   .irq_pending (irq_pending),
   .bus_active  (bus_active),
   .int_n       (int_n),
   .sleep_ok    (sleep_ok),
   .asleep      (asleep),
   .osc_en      (osc_en),
   .clkout_en   (clkout_en),
   .wake_irq    (wake_irq),
   .rx_en       (rx_en)
);

// File: tb/can_sleep_ctl_bench.sv
`timescale 1ns/1ps
module can_sleep_ctl_bench;
   localparam int HB = 4;
   localparam int NROWS = 34;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic set_wr = 1'b0, set_val = 1'b0, reset_mode = 1'b0, irq_pending = 1'b0;
   logic bus_active = 1'b0, int_n = 1'b1, bus_free = 1'b0, bit_tick = 1'b0;
   logic asleep, osc_en, clkout_en, wake_irq, rx_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   can_sleep_ctl #(.HOLD_BITS(HB)) u_can_sleep_ctl (
      .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .set_val(set_val),
      .reset_mode(reset_mode), .irq_pending(irq_pending),
      .bus_active(bus_active), .int_n(int_n), .bus_free(bus_free),
      .bit_tick(bit_tick), .asleep(asleep), .osc_en(osc_en),
      .clkout_en(clkout_en), .wake_irq(wake_irq), .rx_en(rx_en)
   );

   // Row: inputs {wr,val,rm,irqp,busact,int_n,bfree,tick}, expect {asleep,clk,irq,rx}
   localparam logic [11:0] VEC [NROWS] = '{
      12'b1100_0100_0101, // R4 write before bus-free: ignored
      12'b0000_0110_0101, // R4 bus-free arms permission
      12'b1101_0100_0111, // R3 refused, irq pending
      12'b0000_0100_0101, // R7 pulse ends
      12'b1100_1100_0111, // R3 refused, bus active
      12'b0000_0100_0101, // R7
      12'b1100_0100_1100, // R2 enter sleep
      12'b0000_0101_1100, // R5 tick 1
      12'b0000_0101_1100, // R5 tick 2
      12'b0000_0101_1100, // R5 tick 3
      12'b0000_0101_1000, // R5 tick 4 stops clock
      12'b0000_0100_1000, // R5 stays stopped
      12'b1100_0100_1000, // R2 write while asleep: no change
      12'b0000_0000_0111, // R6 wake by int line, rx at once
      12'b0000_0100_0101, // R7 pulse ends
      12'b1100_0100_1100, // R2 sleep again
      12'b0000_0101_1100, // R9 tick 1
      12'b0000_0101_1100, // R9 tick 2
      12'b0000_1100_0110, // R8 bus wake blocks rx
      12'b0000_0100_0100, // R8 still blocked
      12'b0000_0110_0101, // R8 bus-free releases rx
      12'b1100_0100_1100, // R9 re-enter, count restarts
      12'b0000_0101_1100, // R9
      12'b0000_0101_1100, // R9
      12'b0000_0101_1100, // R9 third tick, clock still on
      12'b0000_0101_1000, // R9 full hold reached
      12'b1000_0100_0111, // R6 wake by clearing bit
      12'b0000_0100_0101, // R7
      12'b0010_0100_0101, // R4 reset mode
      12'b1100_0100_0101, // R4 write after reset before bus-free
      12'b0000_0110_0101, // R4 bus-free re-arms
      12'b1100_0100_1100, // R2 sleep
      12'b0010_0100_0101, // R10 reset mode wakes, no irq
      12'b0000_0100_0101  // R10 stays awake
   };
   localparam int REQ [NROWS] = '{4,4,3,7,3,7,2,5,5,5,5,5,2,6,7,2,9,9,8,8,8,9,9,9,9,9,6,7,4,4,4,2,10,10};

   task automatic check4(input int req, input logic [3:0] exp);
      logic [3:0] act;
      act = {asleep, clkout_en, wake_irq, rx_en};
      checks++;
      if (act !== exp || osc_en !== exp[2]) begin
         errors++;
         $display("FAIL R%0d got {asleep,clk,irq,rx}=%b osc=%b expected %b osc=%b",
                  req, act, osc_en, exp, exp[2]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired got running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #25;
      check4(1, 4'b0101);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         {set_wr, set_val, reset_mode, irq_pending, bus_active, int_n, bus_free, bit_tick}
            = VEC[i][11:4];
         @(posedge clk);
         #2;
         check4(REQ[i], VEC[i][3:0]);
      end

      // R1: reset asserted while asleep returns to the reset state
      @(negedge clk);
      {set_wr, set_val, reset_mode, irq_pending, bus_active, int_n, bus_free, bit_tick} = 8'b0000_0110;
      @(negedge clk);
      {set_wr, set_val, bus_free} = 3'b110;
      @(negedge clk);
      {set_wr, set_val} = 2'b00;
      check4(2, 4'b1100);
      rst_n = 1'b0;
      #3;
      check4(1, 4'b0101);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: write right after hardware reset, no bus-free yet
      {set_wr, set_val} = 2'b11;
      @(posedge clk);
      #2;
      check4(4, 4'b0101);
      @(negedge clk);
      {set_wr, set_val} = 2'b00;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule